// File: doc/BRIEF.md
# On-screen display strip sequencer

This block walks one page of an on-screen display held in a 1024-byte RAM. It runs in step with the video timing. A vertical sync pulse picks the page and the top margin height. After that, each scan-line pulse makes the block decide what the line holds. A line can be top margin, part of a spacing strip, part of a character strip, or lie past the end of the page. The block fetches descriptors from the page's list only when the current strip runs out.

On a character-strip line the block re-reads that strip's text string from its start. It interprets the in-line control codes:

- colour selection
- flips
- the multicolour precode
- NOP
- a one-level call/return
- end of line

For every displayable item it sends one command to the downstream pixel stage. A command carries the code, a colour index, a flip mode, a blank flag and the font slice for the current line.

The RAM is reached through a synchronous read port with one cycle of latency. Each RAM byte takes two cycles to fetch and decode. The next scan-line pulse cuts off any row that is still being read.

Top module: `osd_strip_seq`

## Requirements
- R1: After reset, line_kind_o is 0, and cmd_valid_o and ram_rd_o are low.
- R2: vsync_i samples page_i and top_margin_i, and restarts the descriptor walk at address page_i*64. The first top_margin_i*4 lines after it report line_kind_o = 1 (margin). The codes for line_kind_o are: 0 none, 1 margin, 2 spacing, 3 text.
- R3: A descriptor is two bytes: the low byte at the even address and the high byte at the next one. High-byte bit 7 = 0 marks a spacing strip. In a spacing strip, high-byte bit 6 = 1 counts the low byte in scan lines, and bit 6 = 0 counts it in character heights. Spacing lines report kind 2 and issue no commands.
- R4: High-byte bit 7 = 1 marks a character strip, which lasts char_height_i lines. In a character strip:
  - bit 6 is display enable;
  - bit 5 is the colour block;
  - bits 4:2 are the starting colour;
  - bits 1:0 are text address bits 9:8;
  - low-byte bits 7:1 are address bits 7:1, and low-byte bit 0 is ignored.
  A character strip with display enable 0 reports kind 2 and issues no commands.
- R5: The walk ends at a spacing descriptor with count 0, or after 32 descriptors. From then until the next vsync_i, every line reports kind 0.
- R6: A byte 10h..FFh issues a command with that code, cmd_multi_o = 0 and cmd_blank_o = 0.
- R7: Bytes 00h..07h set the current colour. cmd_color_o is {block bit, colour}.
- R8: 0Ah, 0Bh and 0Ch set the flip for the next issued command only. cmd_flip_o bit 0 means horizontal and bit 1 means vertical: 0Ah gives 2, 0Bh gives 1, 0Ch gives 3. Every other command carries flip 0.
- R9: After the precode 08h, the next byte is issued with cmd_multi_o = 1.
- R10: 09h issues nothing and changes no state.
- R11: CALL (0Dh) and RETURN (0Eh) each issue a command with cmd_blank_o = 1 and cmd_code_o equal to the control code.
  - The byte after CALL, b, sends reading to address {0, b, 0}.
  - RETURN resumes just after that byte.
  - A RETURN with no open call continues in sequence.
- R12: 0Fh ends the row. A row also ends after 64 commands.
- R13: cmd_slice_o = floor((36*n + H) / (2*H)), where n is the line index inside the character strip and H is the strip height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Frame start pulse |
| line_i | input | 1 | Scan-line start pulse |
| page_i | input | 4 | Page number, sampled at vsync |
| top_margin_i | input | 8 | Top margin in units of 4 lines, sampled at vsync |
| char_height_i | input | 6 | Character strip height in lines |
| ram_rd_o | output | 1 | RAM read strobe |
| ram_addr_o | output | 10 | RAM read address |
| ram_data_i | input | 8 | RAM read data, one cycle after the strobe |
| line_kind_o | output | 2 | Current line kind |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_code_o | output | 8 | Character or control code |
| cmd_multi_o | output | 1 | Multicolour character |
| cmd_blank_o | output | 1 | Draw as a space |
| cmd_flip_o | output | 2 | Flip mode |
| cmd_color_o | output | 4 | Colour table index |
| cmd_slice_o | output | 5 | Font slice |

## Verification
A wrong descriptor pointer or wrong line counter shows at once in line_kind_o. The error then persists for the rest of the frame, because every later strip boundary moves with it. Faults in decoding the text, such as a flip left pending, a lost colour or a wrong return address, show in the command stream of the very row that contains the code. They then repeat on every line of that strip. A slice error shows only on rows whose line index rounds at one half, so the strip height is chosen to hit that case.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;

  typedef enum logic [1:0] {
    LK_NONE   = 2'd0,
    LK_MARGIN = 2'd1,
    LK_SPACE  = 2'd2,
    LK_TEXT   = 2'd3
  } line_kind_e;

  typedef enum logic [2:0] {
    CC_COLOR,
    CC_PRE,
    CC_NOP,
    CC_FLIP,
    CC_CALL,
    CC_RET,
    CC_EOL,
    CC_CHAR
  } code_class_e;

  typedef struct packed {
    logic       multi;
    logic       blank;
    logic [1:0] flip;
    logic [3:0] color;
    logic [4:0] slice;
    logic [7:0] code;
  } osd_cmd_t;

endpackage

// File: rtl/osd_code_class.sv
module osd_code_class
  import osd_seq_pkg::*;
(
  input  logic [7:0]  code_i,
  output code_class_e class_o,
  output logic [1:0]  flip_o
);
  always_comb begin
    flip_o = 2'b00;
    if (code_i[7:4] != 4'h0) class_o = CC_CHAR;
    else if (code_i[3] == 1'b0) class_o = CC_COLOR;
    else begin
      case (code_i[2:0])
        3'd0: class_o = CC_PRE;
        3'd1: class_o = CC_NOP;
        3'd2: begin class_o = CC_FLIP; flip_o = 2'b10; end
        3'd3: begin class_o = CC_FLIP; flip_o = 2'b01; end
        3'd4: begin class_o = CC_FLIP; flip_o = 2'b11; end
        3'd5: class_o = CC_CALL;
        3'd6: class_o = CC_RET;
        default: class_o = CC_EOL;
      endcase
    end
  end
endmodule

// File: rtl/osd_slice_calc.sv
module osd_slice_calc #(
  parameter int H_W = 6,
  parameter int S_W = 5
) (
  input  logic [H_W-1:0] height_i,
  input  logic [H_W-1:0] idx_i,
  output logic [S_W-1:0] slice_o
);
  localparam int N_W = H_W + 7;

  logic [N_W-1:0] num, den, quo;

  // round(idx*18/height) as floor((36*idx + height) / (2*height))
  always_comb begin
    num = N_W'(idx_i) * N_W'(36) + N_W'(height_i);
    den = N_W'(height_i) << 1;
    if (den == '0) den = N_W'(2);
    quo = num / den;
    slice_o = S_W'(quo);
  end
endmodule

// File: rtl/osd_cmd_out.sv
module osd_cmd_out
  import osd_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  osd_cmd_t cmd_i,
  output logic     valid_o,
  output osd_cmd_t cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cmd_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) cmd_o <= cmd_i;
    end
  end

  p_multi_blank_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(cmd_o.multi && cmd_o.blank));
endmodule

// File: rtl/osd_strip_seq.sv
module osd_strip_seq
  import osd_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 4,
  parameter int PAGE_BYTES = 64,
  parameter int ROW_CHARS  = 64,
  parameter int H_W        = 6,
  parameter int MARGIN_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              line_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [MARGIN_W-1:0] top_margin_i,
  input  logic [H_W-1:0]    char_height_i,
  output logic              ram_rd_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [7:0]        ram_data_i,
  output logic [1:0]        line_kind_o,
  output logic              cmd_valid_o,
  output logic [7:0]        cmd_code_o,
  output logic              cmd_multi_o,
  output logic              cmd_blank_o,
  output logic [1:0]        cmd_flip_o,
  output logic [3:0]        cmd_color_o,
  output logic [4:0]        cmd_slice_o
);
  localparam int MAX_DESC = PAGE_BYTES / 2;
  localparam int DCNT_W   = $clog2(MAX_DESC + 1);
  localparam int CCNT_W   = $clog2(ROW_CHARS + 1);
  localparam int PB_W     = $clog2(PAGE_BYTES);
  localparam int LEFT_W   = 8 + H_W;
  localparam int MCNT_W   = MARGIN_W + 2;
  localparam int S_W      = 5;

  typedef enum logic [2:0] {S_IDLE, S_D0, S_D1, S_D2, S_TREQ, S_TDAT} state_e;

  state_e             state_q;
  line_kind_e         kind_q;
  logic [ADDR_W-1:0]  desc_ptr_q, txt_ptr_q, base_q, ret_q;
  logic [DCNT_W-1:0]  desc_cnt_q;
  logic [MCNT_W-1:0]  margin_q;
  logic [LEFT_W-1:0]  left_q;
  logic [H_W-1:0]     sline_q, height_q;
  logic [S_W-1:0]     slice_q;
  logic [CCNT_W-1:0]  ccnt_q;
  logic [7:0]         lo_q;
  logic [2:0]         col0_q, col_q;
  logic [1:0]         flip_q;
  logic               done_q, is_text_q, blk_q, pre_q, callarg_q, call_act_q;

  // descriptor decode, valid in S_D2 (high byte on ram_data_i)
  logic              d_text, d_de, d_unit, d_end;
  logic [3:0]        d_clu;
  logic [ADDR_W-1:0] d_addr;
  logic [H_W-1:0]    heff;
  logic [LEFT_W-1:0] d_len;

  always_comb begin
    d_text = ram_data_i[7];
    d_de   = ram_data_i[6];
    d_unit = ram_data_i[6];
    d_clu  = ram_data_i[5:2];
    d_addr = ADDR_W'({ram_data_i[1:0], lo_q[7:1], 1'b0});
    heff   = (char_height_i == '0) ? H_W'(1) : char_height_i;
    d_end  = !d_text && (lo_q == 8'h00);
    if (d_text)      d_len = LEFT_W'(heff);
    else if (d_unit) d_len = LEFT_W'(lo_q);
    else             d_len = LEFT_W'(lo_q) * LEFT_W'(heff);
  end

  code_class_e cls_w;
  logic [1:0]  flip_w;
  logic [S_W-1:0] slice_w;

  osd_code_class u_class (
    .code_i (ram_data_i),
    .class_o(cls_w),
    .flip_o (flip_w)
  );

  osd_slice_calc #(.H_W(H_W), .S_W(S_W)) u_slice (
    .height_i(height_q),
    .idx_i   (sline_q),
    .slice_o (slice_w)
  );

  // command issue for the byte being decoded
  logic em, em_multi, em_blank;
  always_comb begin
    em = 1'b0;
    em_multi = 1'b0;
    em_blank = 1'b0;
    if (state_q == S_TDAT && !vsync_i && !line_i && !callarg_q) begin
      if (pre_q) begin
        em = 1'b1;
        em_multi = 1'b1;
      end else begin
        case (cls_w)
          CC_CHAR: em = 1'b1;
          CC_CALL, CC_RET: begin em = 1'b1; em_blank = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  osd_cmd_t cmd_w, cmd_q;
  always_comb begin
    cmd_w.multi = em_multi;
    cmd_w.blank = em_blank;
    cmd_w.flip  = flip_q;
    cmd_w.color = {blk_q, col_q};
    cmd_w.slice = slice_q;
    cmd_w.code  = ram_data_i;
  end

  osd_cmd_out u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(em),
    .cmd_i  (cmd_w),
    .valid_o(cmd_valid_o),
    .cmd_o  (cmd_q)
  );

  assign cmd_code_o  = cmd_q.code;
  assign cmd_multi_o = cmd_q.multi;
  assign cmd_blank_o = cmd_q.blank;
  assign cmd_flip_o  = cmd_q.flip;
  assign cmd_color_o = cmd_q.color;
  assign cmd_slice_o = cmd_q.slice;
  assign line_kind_o = kind_q;

  always_comb begin
    ram_rd_o = (state_q == S_D0) || (state_q == S_D1) || (state_q == S_TREQ);
    case (state_q)
      S_D0:    ram_addr_o = desc_ptr_q;
      S_D1:    ram_addr_o = desc_ptr_q + 1'b1;
      default: ram_addr_o = txt_ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      kind_q     <= LK_NONE;
      desc_ptr_q <= '0;
      txt_ptr_q  <= '0;
      base_q     <= '0;
      ret_q      <= '0;
      desc_cnt_q <= '0;
      margin_q   <= '0;
      left_q     <= '0;
      sline_q    <= '0;
      height_q   <= H_W'(1);
      slice_q    <= '0;
      ccnt_q     <= '0;
      lo_q       <= '0;
      col0_q     <= '0;
      col_q      <= '0;
      flip_q     <= '0;
      done_q     <= 1'b1;
      is_text_q  <= 1'b0;
      blk_q      <= 1'b0;
      pre_q      <= 1'b0;
      callarg_q  <= 1'b0;
      call_act_q <= 1'b0;
    end else if (vsync_i) begin
      state_q    <= S_IDLE;
      kind_q     <= LK_NONE;
      desc_ptr_q <= ADDR_W'(page_i) << PB_W;
      desc_cnt_q <= '0;
      margin_q   <= {top_margin_i, 2'b00};
      left_q     <= '0;
      done_q     <= 1'b0;
      is_text_q  <= 1'b0;
    end else if (line_i) begin
      if (done_q) begin
        kind_q  <= LK_NONE;
        state_q <= S_IDLE;
      end else if (margin_q != '0) begin
        kind_q   <= LK_MARGIN;
        margin_q <= margin_q - 1'b1;
        state_q  <= S_IDLE;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
        if (is_text_q) begin
          kind_q     <= LK_TEXT;
          slice_q    <= slice_w;
          sline_q    <= sline_q + 1'b1;
          txt_ptr_q  <= base_q;
          col_q      <= col0_q;
          flip_q     <= '0;
          pre_q      <= 1'b0;
          callarg_q  <= 1'b0;
          call_act_q <= 1'b0;
          ccnt_q     <= '0;
          state_q    <= S_TREQ;
        end else begin
          kind_q  <= LK_SPACE;
          state_q <= S_IDLE;
        end
      end else if (desc_cnt_q == DCNT_W'(MAX_DESC)) begin
        done_q  <= 1'b1;
        kind_q  <= LK_NONE;
        state_q <= S_IDLE;
      end else begin
        kind_q  <= LK_NONE;
        state_q <= S_D0;
      end
    end else begin
      case (state_q)
        S_D0: state_q <= S_D1;
        S_D1: begin
          lo_q    <= ram_data_i;
          state_q <= S_D2;
        end
        S_D2: begin
          desc_ptr_q <= desc_ptr_q + ADDR_W'(2);
          desc_cnt_q <= desc_cnt_q + 1'b1;
          if (d_end) begin
            done_q  <= 1'b1;
            kind_q  <= LK_NONE;
            state_q <= S_IDLE;
          end else begin
            height_q  <= heff;
            left_q    <= d_len - 1'b1;
            sline_q   <= H_W'(1);
            slice_q   <= '0;
            is_text_q <= d_text && d_de;
            blk_q     <= d_clu[3];
            col0_q    <= d_clu[2:0];
            base_q    <= d_addr;
            if (d_text && d_de) begin
              kind_q     <= LK_TEXT;
              txt_ptr_q  <= d_addr;
              col_q      <= d_clu[2:0];
              flip_q     <= '0;
              pre_q      <= 1'b0;
              callarg_q  <= 1'b0;
              call_act_q <= 1'b0;
              ccnt_q     <= '0;
              state_q    <= S_TREQ;
            end else begin
              kind_q  <= LK_SPACE;
              state_q <= S_IDLE;
            end
          end
        end
        S_TREQ: state_q <= S_TDAT;
        S_TDAT: begin
          state_q   <= S_TREQ;
          txt_ptr_q <= txt_ptr_q + 1'b1;
          if (callarg_q) begin
            callarg_q  <= 1'b0;
            call_act_q <= 1'b1;
            ret_q      <= txt_ptr_q + 1'b1;
            txt_ptr_q  <= ADDR_W'({ram_data_i, 1'b0});
          end else if (pre_q) begin
            pre_q <= 1'b0;
          end else begin
            case (cls_w)
              CC_COLOR: col_q <= ram_data_i[2:0];
              CC_PRE:   pre_q <= 1'b1;
              CC_FLIP:  flip_q <= flip_w;
              CC_CALL:  callarg_q <= 1'b1;
              CC_RET: if (call_act_q) begin
                txt_ptr_q  <= ret_q;
                call_act_q <= 1'b0;
              end
              CC_EOL:   state_q <= S_IDLE;
              default: ;
            endcase
          end
          if (em) begin
            flip_q <= '0;
            ccnt_q <= ccnt_q + 1'b1;
            if (ccnt_q == CCNT_W'(ROW_CHARS - 1)) state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_text_only_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> line_kind_o == LK_TEXT);

  p_vsync_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> (line_kind_o == LK_NONE) && !cmd_valid_o);

  p_slice_range_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_slice_o <= 5'd18);

  p_row_cap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccnt_q <= CCNT_W'(ROW_CHARS));

  p_done_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !vsync_i) |=> done_q);

  p_end_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !cmd_valid_o && !ram_rd_o);

endmodule

// File: tb/osd_strip_seq_tb.sv
module osd_strip_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = 1'b0, line = 1'b0;
  logic [3:0] page = '0;
  logic [7:0] margin = '0;
  logic [5:0] height = 6'd4;
  logic       ram_rd;
  logic [9:0] ram_addr;
  logic [7:0] ram_q = '0;
  logic [1:0] kind;
  logic       cvalid, cmulti, cblank;
  logic [7:0] ccode;
  logic [1:0] cflip;
  logic [3:0] ccolor;
  logic [4:0] cslice;

  logic [7:0]  mem [1024];
  logic [20:0] cap [128];
  int ncap = 0;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  osd_strip_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .line_i(line),
    .page_i(page), .top_margin_i(margin), .char_height_i(height),
    .ram_rd_o(ram_rd), .ram_addr_o(ram_addr), .ram_data_i(ram_q),
    .line_kind_o(kind), .cmd_valid_o(cvalid), .cmd_code_o(ccode),
    .cmd_multi_o(cmulti), .cmd_blank_o(cblank), .cmd_flip_o(cflip),
    .cmd_color_o(ccolor), .cmd_slice_o(cslice)
  );

  always @(posedge clk) if (ram_rd) ram_q <= mem[ram_addr];

  always @(negedge clk)
    if (cvalid && ncap < 128) begin
      cap[ncap] = {cmulti, cblank, cflip, ccolor, cslice, ccode};
      ncap++;
    end

  // per line of page 1: {kind, command count, slice}
  localparam logic [13:0] LINE_TBL [25] = '{
    {2'd1,7'd0,5'd0}, {2'd1,7'd0,5'd0}, {2'd1,7'd0,5'd0}, {2'd1,7'd0,5'd0},
    {2'd3,7'd5,5'd0}, {2'd3,7'd5,5'd5}, {2'd3,7'd5,5'd9}, {2'd3,7'd5,5'd14},
    {2'd2,7'd0,5'd0}, {2'd2,7'd0,5'd0}, {2'd2,7'd0,5'd0},
    {2'd2,7'd0,5'd0}, {2'd2,7'd0,5'd0}, {2'd2,7'd0,5'd0}, {2'd2,7'd0,5'd0},
    {2'd2,7'd0,5'd0}, {2'd2,7'd0,5'd0}, {2'd2,7'd0,5'd0}, {2'd2,7'd0,5'd0},
    {2'd3,7'd7,5'd0}, {2'd3,7'd7,5'd5}, {2'd3,7'd7,5'd9}, {2'd3,7'd7,5'd14},
    {2'd0,7'd0,5'd0}, {2'd0,7'd0,5'd0}
  };
  // {multi, blank, flip, color, code}
  localparam logic [15:0] EXP_A [5] = '{16'h0A41, 16'h1A42, 16'h0D43, 16'h8DF3, 16'h3D44};
  localparam int          TAG_A [5] = '{6, 8, 7, 9, 10};
  localparam logic [15:0] EXP_B [7] = '{16'h0350, 16'h430D, 16'h0360, 16'h430E,
                                        16'h2351, 16'h430E, 16'h0352};
  localparam int          TAG_B [7] = '{6, 11, 11, 11, 8, 11, 6};

  function automatic string tname(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_vsync(input logic [3:0] p, input logic [7:0] m, input logic [5:0] h);
    @(negedge clk);
    page = p; margin = m; height = h; vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_line();
    @(negedge clk);
    ncap = 0;
    line = 1'b1;
    @(negedge clk);
    line = 1'b0;
    repeat (200) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    // page 1 list at 040h
    mem['h040] = 8'h01; mem['h041] = 8'hE9;  // text 100h, de, block 1, colour 2, bit0 set
    mem['h042] = 8'h03; mem['h043] = 8'h40;  // 3 scan lines
    mem['h044] = 8'h01; mem['h045] = 8'h00;  // 1 char height
    mem['h046] = 8'h00; mem['h047] = 8'h80;  // char strip, display off
    mem['h048] = 8'h80; mem['h049] = 8'hCD;  // text 180h, block 0, colour 3
    mem['h04A] = 8'h00; mem['h04B] = 8'h00;  // end
    begin
      logic [7:0] ta [12] = '{8'h41, 8'h0B, 8'h42, 8'h05, 8'h43, 8'h08, 8'hF3,
                             8'h09, 8'h0C, 8'h44, 8'h0F, 8'h99};
      logic [7:0] tb [8]  = '{8'h50, 8'h0D, 8'h90, 8'h0A, 8'h51, 8'h0E, 8'h52, 8'h0F};
      for (int i = 0; i < 12; i++) mem['h100 + i] = ta[i];
      for (int i = 0; i < 8; i++) mem['h180 + i] = tb[i];
    end
    mem['h120] = 8'h60; mem['h121] = 8'h0E;
    // page 2: one text strip of 70 characters
    mem['h080] = 8'h00; mem['h081] = 8'hC2;
    mem['h082] = 8'h00; mem['h083] = 8'h00;
    for (int i = 0; i < 70; i++) mem['h200 + i] = 8'h41;
    mem['h246] = 8'h0F;
    // page 3: 32 one-line spacing strips
    for (int i = 0; i < 32; i++) begin
      mem['h0C0 + 2*i] = 8'h01;
      mem['h0C1 + 2*i] = 8'h40;
    end

    repeat (5) @(negedge clk);
    chk(kind == 2'd0, "R1", kind, 0);
    chk(!cvalid, "R1", cvalid, 0);
    chk(!ram_rd, "R1", ram_rd, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // page 1 walk, margin 4 lines, height 4
    do_vsync(4'd1, 8'd1, 6'd4);
    for (int i = 0; i < 25; i++) begin
      logic [1:0] ek;
      int en;
      string kt;
      do_line();
      ek = LINE_TBL[i][13:12];
      en = int'(LINE_TBL[i][11:5]);
      kt = (i >= 15 && i <= 18) ? "R4" : tname(ek == 2'd0 ? 5 : (ek == 2'd1 ? 2 : (ek == 2'd2 ? 3 : 4)));
      chk(kind == ek, kt, kind, ek);
      chk(ncap == en, (ek == 2'd3) ? "R12" : kt, ncap, en);
      for (int j = 0; j < ncap && j < en; j++)
        chk(cap[j][12:8] == LINE_TBL[i][4:0], "R13", cap[j][12:8], LINE_TBL[i][4:0]);
      if (i == 4)
        for (int j = 0; j < 5 && j < ncap; j++)
          chk({cap[j][20:13], cap[j][7:0]} == EXP_A[j], tname(TAG_A[j]),
              {cap[j][20:13], cap[j][7:0]}, EXP_A[j]);
      if (i == 19)
        for (int j = 0; j < 7 && j < ncap; j++)
          chk({cap[j][20:13], cap[j][7:0]} == EXP_B[j], tname(TAG_B[j]),
              {cap[j][20:13], cap[j][7:0]}, EXP_B[j]);
    end

    // restart of the same page
    do_vsync(4'd1, 8'd1, 6'd4);
    chk(kind == 2'd0, "R2", kind, 0);
    do_line();
    chk(kind == 2'd1, "R2", kind, 1);

    // row cap at 64 commands, height 1
    do_vsync(4'd2, 8'd0, 6'd1);
    do_line();
    chk(kind == 2'd3, "R4", kind, 3);
    chk(ncap == 64, "R12", ncap, 64);
    chk(cap[63][7:0] == 8'h41, "R12", cap[63][7:0], 8'h41);
    do_line();
    chk(kind == 2'd0, "R5", kind, 0);
    chk(ncap == 0, "R5", ncap, 0);

    // 32-descriptor limit
    do_vsync(4'd3, 8'd0, 6'd4);
    for (int i = 0; i < 34; i++) begin
      do_line();
      if (i < 32) chk(kind == 2'd2, "R3", kind, 2);
      else        chk(kind == 2'd0, "R5", kind, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule